// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block turns one of two selectable source clocks into an audio master clock and a serial bit clock. Everything runs in the single domain of `clk`. Each source is presented as a one-cycle tick strobe, one tick per source-clock period, so the block needs no clock multiplexing or gating cells.

The master clock passes through three stages:

- a prescaler that either passes the source through or divides it by 8;
- a modulus divider with a modulus of 1 to 256;
- a toggle stage that divides by two.

The bit clock adds a fine divider of 1 to 16 on top of that chain, so its total ratio is 2·P·M·F.

A whole-chain bypass routes the selected source straight to the master-clock output. A direction control turns the master-clock pin into an input; the fine divider then counts ticks of the external master clock instead. Both outputs have their own polarity inversion. A registered one-cycle enable marks the first cycle of every bit-clock high phase, so a serializer can advance without sampling the clock itself. Divider values are computed elsewhere and presented on plain configuration inputs.

Top module: `audio_clk_divider`

## Requirements
- R1: While `rst_n` is low, the internal master and bit clock levels are 0 and `bclk_ce` is 0. The outputs therefore show the inversion inputs, and `mclk_oe` is 1 unless `mclk_dir_in` is set.
- R2: With bypass off and the pin set as an output, every high and every low phase of the master clock lasts P·M selected-source ticks, which gives a 50% duty cycle. M is `mod_val`+1, so 0 means 1 and 255 means 256.
- R3: `pre_div8`=1 sets P=8, and `pre_div8`=0 sets P=1.
- R4: Every phase of the bit clock lasts P·M·F selected-source ticks, where F is `fine_val`+1 (0 means 1, 15 means 16).
- R5: `src_sel`=0 counts `sys_tick`, and `src_sel`=1 counts `ext_tick`. Ticks of the unselected source have no effect.
- R6: With `bypass`=1, `mclk_out` equals the selected tick XOR `mclk_inv` in every cycle, and each bit-clock phase lasts F selected ticks.
- R7: With `mclk_dir_in`=1, `mclk_oe` is 0 and `mclk_out` is 0. Each bit-clock phase then lasts F ticks of `ext_mclk_tick`.
- R8: `mclk_inv` inverts `mclk_out` and `sck_out` is inverted by `sck_inv`, each independently.
- R9: Prescaler and modulus values are taken up only when the master clock toggles. The fine value is taken up only when the bit clock toggles. A phase already in progress keeps its old length.
- R10: `bclk_ce` is high for exactly one cycle, namely the first cycle in which the uninverted bit clock is high, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sys_tick | input | 1 | System source tick |
| ext_tick | input | 1 | External oscillator source tick |
| src_sel | input | 1 | 0 selects system, 1 selects external |
| pre_div8 | input | 1 | Prescaler divide-by-8 |
| mod_val | input | MOD_W | Modulus minus one |
| fine_val | input | FINE_W | Fine divider minus one |
| bypass | input | 1 | Route source straight to master clock |
| mclk_dir_in | input | 1 | Master-clock pin is an input |
| ext_mclk_tick | input | 1 | Tick of externally driven master clock |
| mclk_inv | input | 1 | Invert master clock |
| sck_inv | input | 1 | Invert bit clock |
| mclk_out | output | 1 | Master clock |
| mclk_oe | output | 1 | Master-clock pin output enable |
| sck_out | output | 1 | Bit clock |
| bclk_ce | output | 1 | One-cycle enable at bit-clock rise |

## Verification
The bench counts source ticks between successive output toggles under random tick patterns. A design that takes the wrong source, mis-scales the prescaler, or is off by one in the modulus or fine count would give phases of the wrong length. It would also give unequal high and low phases if the duty cycle were wrong.

The boundary values M=256 and F=16 are used to catch truncated counters. Changing the modulus right after a toggle must leave the phase in progress at its old length; a design that loads immediately would stretch that phase.

In bypass mode, and with the pin set as an input, the bench checks that the master clock follows the tick, or is released, cycle by cycle. It also checks that the fine divider switches to the external clock. The enable pulse is compared in every cycle with observed bit-clock rises, so a pulse that is late, doubled or tied to the wrong polarity is caught.

// File: rtl/audio_clk_divider.sv
module audio_clk_divider #(
  parameter int MOD_W  = 8,
  parameter int FINE_W = 4,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic              ext_tick,
  input  logic              src_sel,
  input  logic              pre_div8,
  input  logic [MOD_W-1:0]  mod_val,
  input  logic [FINE_W-1:0] fine_val,
  input  logic              bypass,
  input  logic              mclk_dir_in,
  input  logic              ext_mclk_tick,
  input  logic              mclk_inv,
  input  logic              sck_inv,
  output logic              mclk_out,
  output logic              mclk_oe,
  output logic              sck_out,
  output logic              bclk_ce
);

  logic [PRE_W-1:0]  pre_cnt;
  logic              pre_act;
  logic [MOD_W-1:0]  mod_cnt, mod_act;
  logic [FINE_W-1:0] fine_cnt, fine_act;
  logic              mclk_q, sck_q, ce_q;

  logic src_tick, pre_tc, mod_tc, fine_ev, fine_tc;

  assign src_tick = src_sel ? ext_tick : sys_tick;
  assign pre_tc   = src_tick & (~pre_act | (&pre_cnt));
  assign mod_tc   = pre_tc & (mod_cnt == mod_act);
  assign fine_ev  = mclk_dir_in ? ext_mclk_tick : (bypass ? src_tick : mod_tc);
  assign fine_tc  = fine_ev & (fine_cnt == fine_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      pre_act  <= 1'b0;
      mod_cnt  <= '0;
      mod_act  <= '0;
      fine_cnt <= '0;
      fine_act <= '0;
      mclk_q   <= 1'b0;
      sck_q    <= 1'b0;
      ce_q     <= 1'b0;
    end else begin
      if (src_tick) pre_cnt <= pre_act ? pre_cnt + 1'b1 : '0;
      if (pre_tc)   mod_cnt <= mod_tc ? '0 : mod_cnt + 1'b1;
      if (mod_tc) begin
        mclk_q  <= ~mclk_q;
        mod_act <= mod_val;
        pre_act <= pre_div8;
      end
      if (fine_ev) fine_cnt <= fine_tc ? '0 : fine_cnt + 1'b1;
      if (fine_tc) begin
        sck_q    <= ~sck_q;
        fine_act <= fine_val;
      end
      ce_q <= fine_tc & ~sck_q;
    end
  end

  assign mclk_oe  = ~mclk_dir_in;
  assign mclk_out = mclk_dir_in ? 1'b0 : ((bypass ? src_tick : mclk_q) ^ mclk_inv);
  assign sck_out  = sck_q ^ sck_inv;
  assign bclk_ce  = ce_q;

endmodule

// File: rtl/audio_clk_divider_chk.sv
module audio_clk_divider_chk #(
  parameter int MOD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_tick,
  input logic             fine_ev,
  input logic             mclk_q,
  input logic             sck_q,
  input logic [MOD_W-1:0] mod_act,
  input logic             bclk_ce,
  input logic             mclk_dir_in,
  input logic             mclk_oe,
  input logic             mclk_out
);

  p_mclk_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mclk_q) |-> $past(src_tick));

  p_sck_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_q) |-> $past(fine_ev));

  p_pin_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_dir_in |-> (!mclk_oe && !mclk_out));

  p_load_at_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_act) |-> !$stable(mclk_q));

  p_ce_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_ce |-> (sck_q && !$past(sck_q)));

  p_ce_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_ce |=> !bclk_ce);

endmodule

bind audio_clk_divider audio_clk_divider_chk #(.MOD_W(MOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .fine_ev(fine_ev),
  .mclk_q(mclk_q), .sck_q(sck_q), .mod_act(mod_act), .bclk_ce(bclk_ce),
  .mclk_dir_in(mclk_dir_in), .mclk_oe(mclk_oe), .mclk_out(mclk_out)
);

// File: tb/sim_audio_clk_divider.sv
`timescale 1ns/1ps
module sim_audio_clk_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_tick = 0, ext_tick = 0, src_sel = 0, pre_div8 = 0;
  logic [7:0] mod_val = 0;
  logic [3:0] fine_val = 0;
  logic bypass = 0, mclk_dir_in = 0, ext_mclk_tick = 0, mclk_inv = 0, sck_inv = 0;
  logic mclk_out, mclk_oe, sck_out, bclk_ce;

  int checks = 0, fails = 0;
  bit done = 0;
  bit app_sys, app_ext, app_em;
  bit ce_prev = 0;
  int ce_err = 0;

  always #10 clk = ~clk;

  audio_clk_divider u0 (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .ext_tick(ext_tick),
    .src_sel(src_sel), .pre_div8(pre_div8), .mod_val(mod_val), .fine_val(fine_val),
    .bypass(bypass), .mclk_dir_in(mclk_dir_in), .ext_mclk_tick(ext_mclk_tick),
    .mclk_inv(mclk_inv), .sck_inv(sck_inv), .mclk_out(mclk_out), .mclk_oe(mclk_oe),
    .sck_out(sck_out), .bclk_ce(bclk_ce)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_half(input bit p8, input int m, input int f);
    return (p8 ? 8 : 1) * (m + 1) * (f + 1);
  endfunction

  function automatic bit lvl(input bit use_sck);
    return use_sck ? (sck_out ^ sck_inv) : (mclk_out ^ mclk_inv);
  endfunction

  function automatic int applied(input int tsel);
    return (tsel == 0) ? int'(app_sys) : (tsel == 1) ? int'(app_ext) : int'(app_em);
  endfunction

  task automatic cyc();
    bit v;
    @(negedge clk);
    app_sys = sys_tick; app_ext = ext_tick; app_em = ext_mclk_tick;
    v = sck_out ^ sck_inv;
    if (rst_n && (bclk_ce !== (v && !ce_prev))) ce_err++;
    ce_prev = v;
    sys_tick = ($urandom % 2) == 0;
    ext_tick = ($urandom % 3) == 0;
    ext_mclk_tick = ($urandom % 4) == 0;
  endtask

  task automatic wait_toggle(input bit use_sck, input int tsel, output int n);
    bit start, go;
    n = 0; start = lvl(use_sck); go = 1;
    while (go) begin
      cyc();
      n += applied(tsel);
      if (lvl(use_sck) != start) go = 0;
    end
  endtask

  task automatic measure(input bit use_sck, input int tsel, input int exp, input string tag);
    int n;
    wait_toggle(use_sck, tsel, n);
    wait_toggle(use_sck, tsel, n);
    ce_err = 0;
    for (int k = 0; k < 2; k++) begin
      wait_toggle(use_sck, tsel, n);
      check(n == exp, tag, n, exp);
    end
    if (use_sck) check(ce_err == 0, "R10 bclk_ce vs bit-clock rise", ce_err, 0);
  endtask

  task automatic set_cfg(input bit s, input bit p8, input int m, input int f,
                         input bit bp, input bit din, input bit mi, input bit si);
    src_sel = s; pre_div8 = p8; mod_val = m[7:0]; fine_val = f[3:0];
    bypass = bp; mclk_dir_in = din; mclk_inv = mi; sck_inv = si;
    #1 ce_prev = sck_out ^ sck_inv;
  endtask

  initial begin
    void'($urandom(32'h5eed_a0d1));
    #5;
    check(mclk_out == 0 && sck_out == 0 && bclk_ce == 0 && mclk_oe == 1,
          "R1 reset outputs", {mclk_out, sck_out, bclk_ce, mclk_oe}, 4'b0001);
    mclk_inv = 1; sck_inv = 1; #1;
    check(mclk_out == 1, "R8 mclk_inv in reset", mclk_out, 1);
    check(sck_out == 1, "R8 sck_inv in reset", sck_out, 1);
    mclk_dir_in = 1; #1;
    check(mclk_oe == 0 && mclk_out == 0, "R7 pin input in reset", {mclk_oe, mclk_out}, 0);
    mclk_dir_in = 0; mclk_inv = 0; sck_inv = 0;
    repeat (3) @(negedge clk);
    check(bclk_ce == 0, "R1 no enable in reset", bclk_ce, 0);
    rst_n = 1;

    set_cfg(0, 0, 3, 1, 0, 0, 0, 0);
    measure(0, 0, exp_half(0, 3, 0), "R2 mclk phase M=4");
    measure(1, 0, exp_half(0, 3, 1), "R4 sck phase M=4 F=2");

    set_cfg(0, 1, 2, 1, 0, 0, 0, 0);
    measure(0, 0, exp_half(1, 2, 0), "R3 mclk phase P=8 M=3");
    measure(1, 0, exp_half(1, 2, 1), "R3 sck phase P=8 M=3 F=2");

    set_cfg(1, 0, 4, 2, 0, 0, 0, 0);
    measure(0, 1, exp_half(0, 4, 0), "R5 ext source mclk");
    measure(1, 1, exp_half(0, 4, 2), "R5 ext source sck");

    set_cfg(0, 0, 255, 0, 0, 0, 0, 0);
    measure(0, 0, 256, "R2 mclk boundary M=256");

    set_cfg(0, 0, 0, 15, 0, 0, 0, 1);
    measure(1, 0, 16, "R4 sck boundary F=16 inverted");

    set_cfg(1, 0, 5, 3, 1, 0, 1, 0);
    begin
      int bad = 0;
      for (int k = 0; k < 60; k++) begin
        cyc(); #1;
        if (mclk_out !== (ext_tick ^ 1'b1)) bad++;
      end
      check(bad == 0, "R6 bypass mclk follows tick", bad, 0);
    end
    measure(1, 1, 4, "R6 bypass sck F=4");

    set_cfg(0, 1, 7, 2, 0, 1, 0, 0);
    begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        cyc();
        if (mclk_oe !== 1'b0 || mclk_out !== 1'b0) bad++;
      end
      check(bad == 0, "R7 pin released", bad, 0);
    end
    measure(1, 2, 3, "R7 sck from external mclk F=3");

    set_cfg(0, 0, 3, 0, 0, 0, 0, 0);
    measure(0, 0, 4, "R9 setup M=4");
    begin
      int n;
      wait_toggle(0, 0, n);
      mod_val = 8'd9;
      wait_toggle(0, 0, n);
      check(n == 4, "R9 phase in progress keeps old M", n, 4);
      wait_toggle(0, 0, n);
      check(n == 10, "R9 new M after toggle", n, 10);
    end

    for (int it = 0; it < 12; it++) begin
      bit s, p8, mi, si;
      int m, f;
      s = $urandom % 2; p8 = ($urandom % 4) == 0; mi = $urandom % 2; si = $urandom % 2;
      m = $urandom % 6; f = $urandom % 4;
      set_cfg(s, p8, m, f, 0, 0, mi, si);
      measure(0, int'(s), exp_half(p8, m, 0), "R2 random mclk phase");
      measure(1, int'(s), exp_half(p8, m, f), "R4 random sck phase");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all) actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule